// File: doc/BRIEF.md
# DMA Destination Address Generator with Repeat Window

This block keeps the destination address of one DMA channel and moves it forward after each completed transfer. A CPU-side write port loads the 24-bit address. Static configuration inputs select how the address moves after each transfer strobe: it can stay fixed, go up or go down. The step is one for byte transfers and two for word transfers.

A 5-bit window code can restrict the movement to the low n bits of the address. The address then cycles inside an aligned window of 2^n bytes, and the bits above the window never change. When the low bits run past either end of the window, a sticky wrap flag is set. The flag drives an interrupt request when the interrupt enable is high. A configuration error bit records any use of a reserved window code. While such a code is applied, the block treats it as "no window".

Top module: `dst_addr_gen`

## Requirements
- R1: With `upd_mode` equal to 2'b00 or 2'b01 (upper bit 0), a transfer strobe leaves `dst_addr` unchanged.
- R2: With `upd_mode` equal to 2'b10, a strobe adds 1 to the address when `word_sz`=0 and adds 2 when `word_sz`=1.
- R3: With `upd_mode` equal to 2'b11, a strobe subtracts 1 to the address when `word_sz`=0 and subtracts 2 when `word_sz`=1.
- R4: With `area_code`=0, the whole 24-bit address is updated modulo 2^24, and `wrap_flag` is never set.
- R5: With `area_code`=n, for n from 1 to 23, only bits [n-1:0] change. They change modulo 2^n, and bits [23:n] keep their value.
- R6: When a strobe in windowed mode carries the low n bits past the top of the window (up) or below zero (down), `wrap_flag` becomes 1 on that clock edge.
- R7: `irq` is high exactly when `wrap_flag` and `irq_en` are both 1. With `irq_en`=0 a wrap raises no interrupt.
- R8: `wrap_flag` stays set until a cycle with `flag_clr`=1 clears it. If a new wrap happens in the same cycle as a clear, the flag stays set.
- R9: Window codes 24 to 31 are reserved. They act as code 0, and any cycle that applies one sets `cfg_err`, which only reset clears.
- R10: A cycle with `wr_addr_en`=1 loads `wr_addr_data`, and a strobe in that same cycle is dropped.
- R11: After reset, `dst_addr`=0 and `wrap_flag`, `irq` and `cfg_err` are all 0. An update becomes visible on the clock edge that samples the strobe, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_addr_en | input | 1 | Load the address register from `wr_addr_data` |
| wr_addr_data | input | 24 | Address value to load |
| flag_clr | input | 1 | Write-one-to-clear for `wrap_flag` |
| area_code | input | 5 | Window size code: 0 none, n gives 2^n bytes, 24-31 reserved |
| upd_mode | input | 2 | 0x fixed, 10 up, 11 down |
| word_sz | input | 1 | 0 byte step (1), 1 word step (2) |
| irq_en | input | 1 | Wrap interrupt enable |
| xfer_done | input | 1 | One-cycle strobe for a completed transfer |
| dst_addr | output | 24 | Current destination address |
| wrap_flag | output | 1 | Sticky window wrap flag |
| irq | output | 1 | Wrap interrupt request |
| cfg_err | output | 1 | Sticky reserved-code error |

## Verification
The assertions read the mode, size and window inputs in the cycle that carries the strobe. They assume those inputs are valid in that cycle, but they do not need them to stay stable between strobes. The bench changes the configuration only at the falling edge before a strobe and holds it until the update has been checked. The bench sweeps every window code from 0 to 23 against all four modes and both sizes, and it starts from offsets at the bottom, middle and top of each window. Reserved codes appear only in the last phase, because `cfg_err` cannot be cleared once it is set.

// File: rtl/dag_pkg.sv
// Shared definitions for the destination address generator.
// Assumes: update-mode encoding is fixed by the control interface.
package dag_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD_A = 2'b00,
        MODE_HOLD_B = 2'b01,
        MODE_UP     = 2'b10,
        MODE_DOWN   = 2'b11
    } upd_mode_e;
endpackage

// File: rtl/dag_area_decode.sv
// Turns the window code into a low-bit mask.
// Codes above ADDR_W-1 are reserved: they give an empty mask and raise code_bad.
// Assumes: 2**CODE_W >= ADDR_W, so every bit index fits in a code value.
module dag_area_decode #(
    parameter int ADDR_W = 24,
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] area_code,
    output logic [ADDR_W-1:0] win_mask,
    output logic              win_on,
    output logic              code_bad
);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(ADDR_W - 1);

    // Flag the reserved codes.
    always_comb code_bad = (area_code > MAX_CODE);

    // Build the thermometer mask of the window bits.
    generate
        for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_mask
            always_comb win_mask[gi] = !code_bad && (CODE_W'(gi) < area_code);
        end
    endgenerate

    // The window is active when at least one bit is confined.
    always_comb win_on = |win_mask;
endmodule

// File: rtl/dag_step_unit.sv
// Computes the next address and reports a window wrap.
// Assumes: win_mask is a contiguous run of low ones (or all zero).
module dag_step_unit
    import dag_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] win_mask,
    input  logic              win_on,
    input  logic [1:0]        mode,
    input  logic              word_sz,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              wrap_hit
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] low;
    logic [ADDR_W:0]   low_up;
    logic [ADDR_W-1:0] raw;
    logic              over_top;
    logic              under_zero;

    // Select the step size.
    always_comb step = word_sz ? ADDR_W'(2) : ADDR_W'(1);

    // Detect the window edge crossings from the masked low bits.
    always_comb begin
        low        = cur_addr & win_mask;
        low_up     = {1'b0, low} + {1'b0, step};
        over_top   = low_up > {1'b0, win_mask};
        under_zero = low < step;
    end

    // Apply the mode, then merge the window bits with the fixed upper bits.
    always_comb begin
        raw      = cur_addr;
        wrap_hit = 1'b0;
        case (upd_mode_e'(mode))
            MODE_UP: begin
                raw      = cur_addr + step;
                wrap_hit = win_on && over_top;
            end
            MODE_DOWN: begin
                raw      = cur_addr - step;
                wrap_hit = win_on && under_zero;
            end
            default: begin
                raw      = cur_addr;
                wrap_hit = 1'b0;
            end
        endcase
        nxt_addr = win_on ? ((cur_addr & ~win_mask) | (raw & win_mask)) : raw;
    end
endmodule

// File: rtl/dag_flag_ctrl.sv
// Holds the sticky wrap flag and configuration error, and gates the interrupt.
// Assumes: set_pulse and code_bad are single-cycle qualified events.
module dag_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_pulse,
    input  logic code_bad,
    input  logic irq_en,
    output logic wrap_flag,
    output logic cfg_err,
    output logic irq
);
    // Wrap flag: set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         wrap_flag <= 1'b0;
        else if (set_pulse) wrap_flag <= 1'b1;
        else if (clr_pulse) wrap_flag <= 1'b0;
    end

    // Configuration error: sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_err <= 1'b0;
        else if (code_bad) cfg_err <= 1'b1;
    end

    // Interrupt request follows the flag when enabled.
    always_comb irq = wrap_flag & irq_en;

    // R6: a wrap event shows on the flag at the next edge
    a_r6_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> wrap_flag);
    // R8: the flag holds without a clear
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_flag && !clr_pulse) |=> wrap_flag);
    // R8: a clear without a new wrap empties the flag
    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !set_pulse) |=> !wrap_flag);
    // R7: no interrupt while disabled
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    // R9: the error bit never drops outside reset
    a_r9_cfg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

// File: rtl/dst_addr_gen.sv
// Destination address generator for one DMA channel.
// Loads the address from the write port and updates it once per transfer strobe,
// optionally confined to an aligned power-of-two window.
// Assumes: configuration inputs are valid in the strobe cycle.
module dst_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_en,
    input  logic [ADDR_W-1:0] wr_addr_data,
    input  logic              flag_clr,
    input  logic [CODE_W-1:0] area_code,
    input  logic [1:0]        upd_mode,
    input  logic              word_sz,
    input  logic              irq_en,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              wrap_flag,
    output logic              irq,
    output logic              cfg_err
);
    logic [ADDR_W-1:0] win_mask;
    logic              win_on;
    logic              code_bad;
    logic [ADDR_W-1:0] nxt_addr;
    logic              wrap_hit;
    logic              step_en;

    dag_area_decode #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) area_i (
        .area_code (area_code),
        .win_mask  (win_mask),
        .win_on    (win_on),
        .code_bad  (code_bad)
    );

    dag_step_unit #(.ADDR_W(ADDR_W)) step_i (
        .cur_addr (dst_addr),
        .win_mask (win_mask),
        .win_on   (win_on),
        .mode     (upd_mode),
        .word_sz  (word_sz),
        .nxt_addr (nxt_addr),
        .wrap_hit (wrap_hit)
    );

    // A strobe counts only when no register write competes with it.
    always_comb step_en = xfer_done && !wr_addr_en;

    dag_flag_ctrl flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (step_en && wrap_hit),
        .clr_pulse (flag_clr),
        .code_bad  (code_bad),
        .irq_en    (irq_en),
        .wrap_flag (wrap_flag),
        .cfg_err   (cfg_err),
        .irq       (irq)
    );

    // Address register: write first, then the transfer update.
    always_ff @(posedge clk) begin
        if (!rst_n)          dst_addr <= '0;
        else if (wr_addr_en) dst_addr <= wr_addr_data;
        else if (xfer_done)  dst_addr <= nxt_addr;
    end

    // R10: a write always lands, whatever the strobe does
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr_en |=> (dst_addr == $past(wr_addr_data)));
    // R1: hold modes leave the address alone
    a_r1_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !upd_mode[1]) |=> $stable(dst_addr));
    // R5: bits above the window never move on a strobe
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && win_on) |=>
        (((dst_addr ^ $past(dst_addr)) & ~$past(win_mask)) == '0));
    // R2: unwindowed byte increment adds one
    a_r2_byte_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && upd_mode == 2'b10 && !word_sz && area_code == '0)
        |=> (dst_addr == $past(dst_addr) + ADDR_W'(1)));
    // R11: without write or strobe the address does not move
    a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_addr_en && !xfer_done) |=> $stable(dst_addr));
endmodule

// File: tb/dst_addr_gen_tb.sv
`timescale 1ns/1ps
module dst_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_addr_en = 1'b0;
    logic [23:0] wr_addr_data = '0;
    logic        flag_clr = 1'b0;
    logic [4:0]  area_code = '0;
    logic [1:0]  upd_mode = '0;
    logic        word_sz = 1'b0;
    logic        irq_en = 1'b0;
    logic        xfer_done = 1'b0;
    logic [23:0] dst_addr;
    logic        wrap_flag, irq, cfg_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dst_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_addr_en(wr_addr_en), .wr_addr_data(wr_addr_data),
        .flag_clr(flag_clr), .area_code(area_code), .upd_mode(upd_mode),
        .word_sz(word_sz), .irq_en(irq_en), .xfer_done(xfer_done),
        .dst_addr(dst_addr), .wrap_flag(wrap_flag), .irq(irq), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Arithmetic model: window of 2^n bytes, or the full 2^24 space.
    function automatic void model(input longint a, input int n, input int md, input int w,
                                  output longint na, output bit wr);
        longint win  = (n >= 1 && n <= 23) ? (64'd1 << n) : (64'd1 << 24);
        longint st   = w ? 2 : 1;
        longint base = a - (a % win);
        longint low  = a % win;
        longint nl;
        wr = 1'b0;
        if (md < 2) na = a;
        else if (md == 2) begin
            nl = low + st; wr = (nl >= win); na = base + (nl % win);
        end else begin
            nl = low - st; wr = (nl < 0); na = base + ((nl + win) % win);
        end
        if (!(n >= 1 && n <= 23)) wr = 1'b0;
    endfunction

    task automatic load(input logic [23:0] a);
        @(negedge clk);
        wr_addr_en = 1'b1; wr_addr_data = a; flag_clr = 1'b1;
        @(negedge clk);
        wr_addr_en = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        longint na;
        bit     wr;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset addr", dst_addr, 24'h0);
        chk("R11 reset flags", {21'b0, wrap_flag, irq, cfg_err}, 24'h0);
        rst_n = 1'b1;

        // Sweep windows 0..23 x modes x sizes x start offsets (R1-R7 each named below)
        for (int n = 0; n <= 23; n++) begin
            for (int md = 0; md < 4; md++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int k = 0; k < 3; k++) begin
                        longint win = (n == 0) ? (64'd1 << 24) : (64'd1 << n);
                        longint off = (k == 0) ? 0 : (k == 1) ? win - 1 : win / 2;
                        longint a   = (64'hA5C3E7 / win) * win + off;
                        string  rq;
                        area_code = 5'(n); upd_mode = 2'(md); word_sz = w[0];
                        irq_en = (k != 2);
                        load(24'(a));
                        strobe();
                        model(a, n, md, w, na, wr);
                        rq = (md < 2) ? "R1" : (n == 0) ? "R4" : (n > 0 && md == 2) ? "R5/R2" : "R5/R3";
                        chk(rq, dst_addr, 24'(na));
                        chk("R6 flag", {23'b0, wrap_flag}, {23'b0, wr});
                        chk("R7 irq", {23'b0, irq}, {23'b0, wr & irq_en});
                    end
                end
            end
        end
        chk("R9 no error on legal codes", {23'b0, cfg_err}, 24'h0);

        // R2 / R3 direct step sizes without window
        area_code = 0; upd_mode = 2'b10; word_sz = 1'b1;
        load(24'h001000); strobe();
        chk("R2 word up", dst_addr, 24'h001002);
        upd_mode = 2'b11; word_sz = 1'b0; strobe();
        chk("R3 byte down", dst_addr, 24'h001001);
        // R4 full-space wrap with no flag
        load(24'hFFFFFF); upd_mode = 2'b10; strobe();
        chk("R4 full wrap", dst_addr, 24'h000000);
        chk("R4 no flag", {23'b0, wrap_flag}, 24'h0);

        // R8 sticky flag, clear, and set beating clear
        area_code = 5'd4; upd_mode = 2'b10; word_sz = 1'b0; irq_en = 1'b1;
        load(24'h12345F); strobe();
        chk("R8 flag set", {23'b0, wrap_flag}, 24'h1);
        strobe();
        chk("R8 flag held", {23'b0, wrap_flag}, 24'h1);
        chk("R5 window bits", dst_addr, 24'h123451);
        @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R8 flag cleared", {23'b0, wrap_flag}, 24'h0);
        chk("R7 irq cleared", {23'b0, irq}, 24'h0);
        load(24'h12345F);
        @(negedge clk); xfer_done = 1'b1; flag_clr = 1'b1;
        @(negedge clk); xfer_done = 1'b0; flag_clr = 1'b0;
        chk("R8 set wins", {23'b0, wrap_flag}, 24'h1);
        irq_en = 1'b0; #1;
        chk("R7 irq off", {23'b0, irq}, 24'h0);

        // R10 write wins over a same-cycle strobe
        @(negedge clk); wr_addr_en = 1'b1; wr_addr_data = 24'h0ABCDE; xfer_done = 1'b1;
        @(negedge clk); wr_addr_en = 1'b0; xfer_done = 1'b0;
        chk("R10 write wins", dst_addr, 24'h0ABCDE);
        @(negedge clk);
        chk("R10 strobe dropped", dst_addr, 24'h0ABCDE);

        // R11 update is not visible before the sampling edge
        area_code = 0; upd_mode = 2'b10;
        @(negedge clk); xfer_done = 1'b1; #1;
        chk("R11 before edge", dst_addr, 24'h0ABCDE);
        @(negedge clk); xfer_done = 1'b0;
        chk("R11 after edge", dst_addr, 24'h0ABCDF);

        // R9 reserved code acts as code 0 and sets sticky error
        area_code = 5'd24; upd_mode = 2'b10; word_sz = 1'b0;
        load(24'h00FFFF); strobe();
        chk("R9 reserved as none", dst_addr, 24'h010000);
        chk("R9 no wrap flag", {23'b0, wrap_flag}, 24'h0);
        chk("R9 cfg_err set", {23'b0, cfg_err}, 24'h1);
        area_code = 5'd31; load(24'h7FFFFF); upd_mode = 2'b11; strobe();
        chk("R9 code 31 as none", dst_addr, 24'h7FFFFE);
        area_code = 5'd0; repeat (3) @(negedge clk);
        chk("R9 cfg_err sticky", {23'b0, cfg_err}, 24'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule